// File: doc/BRIEF.md
# Write-Policy Selectable Line Cache Controller

The block is a small line-granular cache that sits between a processor request port and a main memory that is addressed by whole lines. It keeps a tag directory with valid bits and a data array. For each request it decides hit or miss and then carries out the write policy fixed by the `POLICY` parameter: write-through where a write miss goes to memory only (`WT_DIRECT`), write-through where a write miss first allocates the line (`WT_FETCH`), or write-back with one dirty bit per entry (`WRITE_BACK`). The `WAYS` parameter selects a direct-mapped directory (1) or a 2-way set-associative one (2). In 2-way mode each set has a single LRU bit.

With the defaults, memory has 128 lines and the cache has 8 lines of 64 bits, so addresses are 7 bits wide. Direct-mapped mode splits an address into a 3-bit index and a 4-bit tag. 2-way mode splits it into a 2-bit set and a 5-bit tag, and compares both ways in the same cycle. Only one request is handled at a time. The processor pulses `cpu_req` while the controller is idle and waits for the one-cycle `cpu_done`.

The controller state machine has six states:
- `S_IDLE` goes to `S_LOOKUP` when a request arrives.
- `S_LOOKUP` can go to one of four states:
  - `S_DONE` on a read hit, or on a write hit under write-back.
  - `S_MEMWR` on a write hit under write-through, or on a write miss under `WT_DIRECT`.
  - `S_EVICT` on a miss under write-back when the victim is dirty.
  - `S_FILL` on any other miss.
- `S_EVICT` goes to `S_FILL` on `mem_ready`.
- `S_FILL` installs the line on `mem_ready` and goes back to `S_LOOKUP`, where the request now hits.
- `S_MEMWR` goes to `S_DONE` on `mem_ready`.
- `S_DONE` goes to `S_IDLE`.

Top module: `cwp_cache_ctrl`

## Requirements
- R1: After reset, `cpu_done`, `mem_rd` and `mem_wr` are low, and every directory entry is invalid. The first access to any address is therefore a miss.
- R2: Direct-mapped mode uses address bits [2:0] as the index and [6:3] as the tag. 2-way mode uses bits [1:0] as the set and [6:2] as the tag. In 2-way mode, two lines with the same set bits and different tags can both stay resident.
- R3: A request is sampled only in `S_IDLE`. `cpu_done` is high for exactly one cycle per request.
- R4: A read hit returns the cached line on `cpu_rdata` with no memory request.
- R5: A read miss issues exactly one `mem_rd` for the request address. It then returns that line, and the line is resident afterwards.
- R6: Under either write-through policy, a write hit updates the cached line and issues exactly one `mem_wr` of the data to the request address.
- R7: Under `WT_DIRECT`, a write miss issues one `mem_wr` and no `mem_rd`, and leaves the directory unchanged. A later read of that address misses.
- R8: Under `WT_FETCH`, a write miss issues one `mem_rd`, replaces the old tag at that index, writes the cache and then issues one `mem_wr`. A later read hits and returns the new data.
- R9: Under `WRITE_BACK`, a write hit marks the line dirty and makes no memory access. Memory keeps its old value.
- R10: Under `WRITE_BACK`, a miss whose victim is dirty first writes the victim's data to the victim's address, then fetches the new line. A refilled line is clean, so evicting it later causes no write.
- R11: In 2-way mode the victim is an invalid way if there is one. Otherwise it is the way not touched most recently, where both hits and fills count as touches.
- R12: `mem_rd` and `mem_wr` are never high together. Once raised, each stays high with a stable address and data until the cycle in which `mem_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Request strobe, sampled in idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address |
| cpu_wdata | input | DATA_W | Write data (whole line) |
| cpu_rdata | output | DATA_W | Read data, valid when `cpu_done` is high |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_rd | output | 1 | Line fetch request |
| mem_wr | output | 1 | Line write request |
| mem_addr | output | ADDR_W | Memory line address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Fetched line, valid with `mem_ready` |
| mem_ready | input | 1 | Memory completes the current request |

## Verification
Most wrong internal states reach the memory port before they reach the processor port, so the bench counts reads and writes per request in three configurations running in lockstep.
- A valid bit or tag that is wrong turns an expected hit into a fetch, or the reverse, and this shows up on the same request.
- A dirty bit that is wrong stays hidden until its line is chosen as a victim. Its effect is a missing or extra write, or stale memory contents, several requests later.
- An LRU bit that is wrong moves the eviction to the other way. It becomes visible on the next conflicting miss, and again when the evicted address is read back.

// File: rtl/cwp_pkg.sv
package cwp_pkg;

    typedef enum logic [1:0] {
        WT_DIRECT  = 2'd0,
        WT_FETCH   = 2'd1,
        WRITE_BACK = 2'd2
    } wpolicy_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_LOOKUP = 3'd1,
        S_EVICT  = 3'd2,
        S_FILL   = 3'd3,
        S_MEMWR  = 3'd4,
        S_DONE   = 3'd5
    } ctl_state_e;

endpackage

// File: rtl/cwp_tag_dir.sv
module cwp_tag_dir #(
    parameter int WAYS  = 2,
    parameter int SETS  = 4,
    parameter int SET_W = 2,
    parameter int TAG_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [SET_W-1:0]            rd_set,
    output logic [WAYS-1:0]             rd_valid,
    output logic [WAYS-1:0]             rd_dirty,
    output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
    output logic                        rd_lru,
    input  logic                        fill_en,
    input  logic                        dirty_en,
    input  logic                        touch_en,
    input  logic [SET_W-1:0]            upd_set,
    input  logic                        upd_way,
    input  logic [TAG_W-1:0]            upd_tag
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  valid_q;
        logic [SETS-1:0]  dirty_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic             sel;

        assign sel = (upd_way == 1'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else if (fill_en && sel) begin
                valid_q[upd_set] <= 1'b1;
                dirty_q[upd_set] <= 1'b0;
            end else if (dirty_en && sel) begin
                dirty_q[upd_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && sel) begin
                tag_q[upd_set] <= upd_tag;
            end
        end

        assign rd_valid[w] = valid_q[rd_set];
        assign rd_dirty[w] = dirty_q[rd_set];
        assign rd_tag[w]   = tag_q[rd_set];
    end

    if (WAYS == 2) begin : g_lru
        logic [SETS-1:0] lru_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lru_q <= '0;
            end else if (touch_en) begin
                lru_q[upd_set] <= ~upd_way;
            end
        end

        assign rd_lru = lru_q[rd_set];

        // R11: after a touch, the recorded victim differs from the touched way
        a_r11_lru_points_away: assert property (@(posedge clk) disable iff (!rst_n)
            (touch_en && rd_set == upd_set) |=> (rd_lru != $past(upd_way)));
    end else begin : g_no_lru
        assign rd_lru = 1'b0;
    end

endmodule

// File: rtl/cwp_hit_check.sv
module cwp_hit_check #(
    parameter int WAYS  = 2,
    parameter int TAG_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            req_tag,
    input  logic                        lru,
    output logic                        hit,
    output logic                        hit_way,
    output logic                        vic_way
);

    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = valid[w] && (tags[w] == req_tag);
    end

    assign hit = |match;

    if (WAYS == 2) begin : g_two
        assign hit_way = match[1];
        always_comb begin
            if (!valid[0]) begin
                vic_way = 1'b0;
            end else if (!valid[1]) begin
                vic_way = 1'b1;
            end else begin
                vic_way = lru;
            end
        end
    end else begin : g_one
        logic unused_lru;
        assign unused_lru = lru;
        assign hit_way    = 1'b0;
        assign vic_way    = 1'b0;
    end

    // R2: a tag is resident in at most one way of a set
    a_r2_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/cwp_data_array.sv
module cwp_data_array #(
    parameter int WAYS   = 2,
    parameter int SETS   = 4,
    parameter int SET_W  = 2,
    parameter int DATA_W = 64
) (
    input  logic                         clk,
    input  logic                         wr_en,
    input  logic                         wr_way,
    input  logic [SET_W-1:0]             wr_set,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic [SET_W-1:0]             rd_set,
    output logic [WAYS-1:0][DATA_W-1:0]  rd_data
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [DATA_W-1:0] line_q [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == 1'(w))) begin
                line_q[wr_set] <= wr_data;
            end
        end

        assign rd_data[w] = line_q[rd_set];
    end

endmodule

// File: rtl/cwp_cache_ctrl.sv
module cwp_cache_ctrl
    import cwp_pkg::*;
#(
    parameter int       ADDR_W = 7,
    parameter int       LINES  = 8,
    parameter int       DATA_W = 64,
    parameter int       WAYS   = 2,
    parameter wpolicy_e POLICY = WRITE_BACK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_done,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    localparam int SETS  = LINES / WAYS;
    localparam int SET_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - SET_W;

    ctl_state_e state, nxt;

    logic [ADDR_W-1:0] req_addr;
    logic              req_we;
    logic [DATA_W-1:0] req_wdata;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;

    logic [WAYS-1:0]             dir_valid;
    logic [WAYS-1:0]             dir_dirty;
    logic [WAYS-1:0][TAG_W-1:0]  dir_tag;
    logic                        dir_lru;
    logic [WAYS-1:0][DATA_W-1:0] line_rd;

    logic hit, hit_way, vic_way, vic_way_q, vic_dirty, upd_way;
    logic fill_en, dirty_en, touch_en, dwr_en, rdata_ld, vic_ld;
    logic [DATA_W-1:0] dwr_data;

    assign req_set = req_addr[SET_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:SET_W];

    cwp_tag_dir #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_set   (req_set),
        .rd_valid (dir_valid),
        .rd_dirty (dir_dirty),
        .rd_tag   (dir_tag),
        .rd_lru   (dir_lru),
        .fill_en  (fill_en),
        .dirty_en (dirty_en),
        .touch_en (touch_en),
        .upd_set  (req_set),
        .upd_way  (upd_way),
        .upd_tag  (req_tag)
    );

    cwp_hit_check #(.WAYS(WAYS), .TAG_W(TAG_W)) u_hit (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (dir_valid),
        .tags    (dir_tag),
        .req_tag (req_tag),
        .lru     (dir_lru),
        .hit     (hit),
        .hit_way (hit_way),
        .vic_way (vic_way)
    );

    cwp_data_array #(.WAYS(WAYS), .SETS(SETS), .SET_W(SET_W), .DATA_W(DATA_W)) u_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .wr_way  (upd_way),
        .wr_set  (req_set),
        .wr_data (dwr_data),
        .rd_set  (req_set),
        .rd_data (line_rd)
    );

    assign vic_dirty = dir_valid[vic_way] && dir_dirty[vic_way];
    assign upd_way   = (state == S_FILL) ? vic_way_q : hit_way;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // request capture, victim and read data holding registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr  <= '0;
            req_we    <= 1'b0;
            req_wdata <= '0;
            vic_way_q <= 1'b0;
            cpu_rdata <= '0;
        end else begin
            if (state == S_IDLE && cpu_req) begin
                req_addr  <= cpu_addr;
                req_we    <= cpu_we;
                req_wdata <= cpu_wdata;
            end
            if (vic_ld) begin
                vic_way_q <= vic_way;
            end
            if (rdata_ld) begin
                cpu_rdata <= line_rd[hit_way];
            end
        end
    end

    // next state and internal control
    always_comb begin
        nxt      = state;
        fill_en  = 1'b0;
        dirty_en = 1'b0;
        touch_en = 1'b0;
        dwr_en   = 1'b0;
        dwr_data = req_wdata;
        rdata_ld = 1'b0;
        vic_ld   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (cpu_req) begin
                    nxt = S_LOOKUP;
                end
            end
            S_LOOKUP: begin
                if (hit) begin
                    touch_en = 1'b1;
                    if (req_we) begin
                        dwr_en = 1'b1;
                        if (POLICY == WRITE_BACK) begin
                            dirty_en = 1'b1;
                            nxt      = S_DONE;
                        end else begin
                            nxt = S_MEMWR;
                        end
                    end else begin
                        rdata_ld = 1'b1;
                        nxt      = S_DONE;
                    end
                end else begin
                    vic_ld = 1'b1;
                    if (req_we && POLICY == WT_DIRECT) begin
                        nxt = S_MEMWR;
                    end else if (POLICY == WRITE_BACK && vic_dirty) begin
                        nxt = S_EVICT;
                    end else begin
                        nxt = S_FILL;
                    end
                end
            end
            S_EVICT: begin
                if (mem_ready) begin
                    nxt = S_FILL;
                end
            end
            S_FILL: begin
                if (mem_ready) begin
                    fill_en  = 1'b1;
                    touch_en = 1'b1;
                    dwr_en   = 1'b1;
                    dwr_data = mem_rdata;
                    nxt      = S_LOOKUP;
                end
            end
            S_MEMWR: begin
                if (mem_ready) begin
                    nxt = S_DONE;
                end
            end
            S_DONE: begin
                nxt = S_IDLE;
            end
            default: begin
                nxt = S_IDLE;
            end
        endcase
    end

    // port outputs
    always_comb begin
        cpu_done  = (state == S_DONE);
        mem_rd    = (state == S_FILL);
        mem_wr    = (state == S_EVICT) || (state == S_MEMWR);
        mem_addr  = req_addr;
        mem_wdata = req_wdata;
        if (state == S_EVICT) begin
            mem_addr  = {dir_tag[vic_way_q], req_set};
            mem_wdata = line_rd[vic_way_q];
        end
    end

    // R12: the memory port never asks for both directions
    a_r12_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R12: a fetch is held with a stable address until accepted
    a_r12_rd_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

    // R12: a write is held with stable address and data until accepted
    a_r12_wr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    // R5: a completed fetch makes the request hit on the following cycle
    a_r5_fill_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_ready) |=> hit);

    if (POLICY == WT_DIRECT) begin : g_chk_direct
        // R7: no allocation is ever made for a write
        a_r7_no_fetch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            mem_rd |-> !req_we);
    end

    if (POLICY == WRITE_BACK) begin : g_chk_wb
        // R10: every memory write carries a dirty victim, never the requested line
        a_r10_write_is_victim: assert property (@(posedge clk) disable iff (!rst_n)
            mem_wr |-> (mem_addr != req_addr && dir_dirty[vic_way_q]));
    end

endmodule

// File: tb/cwp_mem_model.sv
module cwp_mem_model #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ready,
    output int                rd_cnt,
    output int                wr_cnt
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic              wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) begin
                store[a] <= {32'hA5A5_0000, 24'h0, 8'(a)};
            end
            ready  <= 1'b0;
            wait_q <= 1'b0;
            rdata  <= '0;
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else if (ready) begin
            ready  <= 1'b0;
            wait_q <= 1'b0;
        end else if (rd || wr) begin
            if (wait_q) begin
                ready <= 1'b1;
                if (wr) begin
                    store[addr] <= wdata;
                    wr_cnt      <= wr_cnt + 1;
                end else begin
                    rdata  <= store[addr];
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wait_q <= 1'b1;
            end
        end
    end

endmodule

// File: tb/test_cwp_cache_ctrl.sv
module test_cwp_cache_ctrl;
    import cwp_pkg::*;

    localparam int AW = 7;
    localparam int DW = 64;
    localparam logic [DW-1:0] D1 = 64'hD1D1_0101_2323_4545;
    localparam logic [DW-1:0] D2 = 64'hD2D2_6767_8989_ABAB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;

    // instance 0: write-back 2-way, 1: write-through direct write DM, 2: write-through fetch DM
    logic [DW-1:0] rd0, rd1, rd2, mwd0, mwd1, mwd2, mrd0, mrd1, mrd2;
    logic          dn0, dn1, dn2, mr0, mr1, mr2, mw0, mw1, mw2, rdy0, rdy1, rdy2;
    logic [AW-1:0] ma0, ma1, ma2;
    int            rc0, rc1, rc2, wc0, wc1, wc2;

    cwp_cache_ctrl #(.WAYS(2), .POLICY(WRITE_BACK)) i_cwp_cache_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rd0), .cpu_done(dn0), .mem_rd(mr0), .mem_wr(mw0),
        .mem_addr(ma0), .mem_wdata(mwd0), .mem_rdata(mrd0), .mem_ready(rdy0));
    cwp_mem_model #(.ADDR_W(AW), .DATA_W(DW)) m_wb (
        .clk(clk), .rst_n(rst_n), .rd(mr0), .wr(mw0), .addr(ma0), .wdata(mwd0),
        .rdata(mrd0), .ready(rdy0), .rd_cnt(rc0), .wr_cnt(wc0));

    cwp_cache_ctrl #(.WAYS(1), .POLICY(WT_DIRECT)) i_wtd (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rd1), .cpu_done(dn1), .mem_rd(mr1), .mem_wr(mw1),
        .mem_addr(ma1), .mem_wdata(mwd1), .mem_rdata(mrd1), .mem_ready(rdy1));
    cwp_mem_model #(.ADDR_W(AW), .DATA_W(DW)) m_wtd (
        .clk(clk), .rst_n(rst_n), .rd(mr1), .wr(mw1), .addr(ma1), .wdata(mwd1),
        .rdata(mrd1), .ready(rdy1), .rd_cnt(rc1), .wr_cnt(wc1));

    cwp_cache_ctrl #(.WAYS(1), .POLICY(WT_FETCH)) i_wtf (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rd2), .cpu_done(dn2), .mem_rd(mr2), .mem_wr(mw2),
        .mem_addr(ma2), .mem_wdata(mwd2), .mem_rdata(mrd2), .mem_ready(rdy2));
    cwp_mem_model #(.ADDR_W(AW), .DATA_W(DW)) m_wtf (
        .clk(clk), .rst_n(rst_n), .rd(mr2), .wr(mw2), .addr(ma2), .wdata(mwd2),
        .rdata(mrd2), .ready(rdy2), .rd_cnt(rc2), .wr_cnt(wc2));

    int total = 0;
    int bad = 0;

    typedef struct packed { logic chk; logic [DW-1:0] val; } exp_t;
    exp_t exp_q[$];
    exp_t cur;
    logic seen0, seen1, seen2, prev_dn;

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return {32'hA5A5_0000, 24'h0, 8'(a)};
    endfunction

    task automatic check(input logic ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard for the write-back instance, compares the other two
    always @(negedge clk) begin
        if (rst_n) begin
            if (dn0 && prev_dn) check(1'b0, "R3 done longer than one cycle", 64'(dn0), 64'd0);
            prev_dn = dn0;
            if (dn0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected done", 64'd1, 64'd0);
                end else begin
                    cur = exp_q.pop_front();
                    if (cur.chk) check(rd0 == cur.val, "R4/R5 rdata write-back", rd0, cur.val);
                end
                seen0 = 1'b1;
            end
            if (dn1) begin
                if (cur.chk) check(rd1 == cur.val, "R4/R5 rdata direct-write", rd1, cur.val);
                seen1 = 1'b1;
            end
            if (dn2) begin
                if (cur.chk) check(rd2 == cur.val, "R4/R5 rdata fetch-on-write", rd2, cur.val);
                seen2 = 1'b1;
            end
        end else begin
            prev_dn = 1'b0;
        end
    end

    // driver: one request to all three, then traffic deltas against expectations
    task automatic op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input logic [DW-1:0] exp_rd, input string req,
                      input int er0, input int ew0, input int er1, input int ew1,
                      input int er2, input int ew2);
        int b0r, b0w, b1r, b1w, b2r, b2w, guard;
        exp_t e;
        b0r = rc0; b0w = wc0; b1r = rc1; b1w = wc1; b2r = rc2; b2w = wc2;
        e.chk = !we;
        e.val = exp_rd;
        exp_q.push_back(e);
        cur = e;
        seen0 = 1'b0; seen1 = 1'b0; seen2 = 1'b0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        guard = 0;
        while (!(seen0 && seen1 && seen2) && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(guard < 200, {req, " completion"}, 64'(guard), 64'd0);
        check(rc0 - b0r == er0 && wc0 - b0w == ew0, {req, " write-back traffic"},
              64'((rc0 - b0r) * 16 + (wc0 - b0w)), 64'(er0 * 16 + ew0));
        check(rc1 - b1r == er1 && wc1 - b1w == ew1, {req, " direct-write traffic"},
              64'((rc1 - b1r) * 16 + (wc1 - b1w)), 64'(er1 * 16 + ew1));
        check(rc2 - b2r == er2 && wc2 - b2w == ew2, {req, " fetch-on-write traffic"},
              64'((rc2 - b2r) * 16 + (wc2 - b2w)), 64'(er2 * 16 + ew2));
        @(negedge clk);
        check(!dn0 && !dn1 && !dn2, "R3 done low after pulse", 64'({dn0, dn1, dn2}), 64'd0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet ports after reset
        check(!dn0 && !dn1 && !dn2, "R1 done low", 64'({dn0, dn1, dn2}), 64'd0);
        check(!(mr0 | mw0 | mr1 | mw1 | mr2 | mw2), "R1 memory idle",
              64'({mr0, mw0, mr1, mw1, mr2, mw2}), 64'd0);

        // R1 R5: cold read misses in every configuration (address 0x1A: index 2 / set 2)
        op(1'b0, 7'h1A, '0, init_val(7'h1A), "R1 R5 cold read", 1, 0, 1, 0, 1, 0);
        // R4: repeat read hits with no traffic
        op(1'b0, 7'h1A, '0, init_val(7'h1A), "R4 read hit", 0, 0, 0, 0, 0, 0);
        // R6 R9: write hit
        op(1'b1, 7'h1A, D1, '0, "R6 R9 write hit", 0, 0, 0, 1, 0, 1);
        check(m_wb.store[7'h1A] == init_val(7'h1A), "R9 memory untouched",
              m_wb.store[7'h1A], init_val(7'h1A));
        check(m_wtd.store[7'h1A] == D1, "R6 direct-write memory", m_wtd.store[7'h1A], D1);
        check(m_wtf.store[7'h1A] == D1, "R6 fetch-on-write memory", m_wtf.store[7'h1A], D1);
        op(1'b0, 7'h1A, '0, D1, "R4 R6 read after write", 0, 0, 0, 0, 0, 0);

        // R7 R8 R2: write miss to 0x02, same index as 0x1A
        op(1'b1, 7'h02, D2, '0, "R7 R8 R2 write miss", 1, 0, 0, 1, 1, 1);
        check(m_wtd.store[7'h02] == D2, "R7 memory written", m_wtd.store[7'h02], D2);
        // R7: direct write left the directory alone, so this read misses; R8: hits
        op(1'b0, 7'h02, '0, D2, "R7 R8 read after write miss", 0, 0, 1, 0, 0, 0);
        // R2: 2-way keeps both 0x1A and 0x02; direct-mapped lost 0x1A
        op(1'b0, 7'h1A, '0, D1, "R2 conflict read", 0, 0, 1, 0, 1, 0);

        // R10 R11: 0x42 conflicts; LRU victim is 0x02 (dirty)
        op(1'b0, 7'h42, '0, init_val(7'h42), "R10 R11 dirty eviction", 1, 1, 1, 0, 1, 0);
        check(m_wb.store[7'h02] == D2, "R10 victim written back", m_wb.store[7'h02], D2);
        // R11: victim now 0x1A (dirty)
        op(1'b0, 7'h02, '0, D2, "R10 R11 second eviction", 1, 1, 1, 0, 1, 0);
        check(m_wb.store[7'h1A] == D1, "R10 second victim written", m_wb.store[7'h1A], D1);
        // R11: touch 0x42 so the clean refilled 0x02 becomes the victim
        op(1'b0, 7'h42, '0, init_val(7'h42), "R11 hit updates LRU", 0, 0, 1, 0, 1, 0);
        // R10: refilled line is clean, so no write when it is evicted
        op(1'b0, 7'h1A, '0, D1, "R10 clean refill evicted", 1, 0, 1, 0, 1, 0);

        check(exp_q.size() == 0, "R3 scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule